// File: doc/BRIEF.md
# Serial Flash Status and Protection Register Unit

This block is the register and write-protection logic behind the SPI slave port of a serial flash device. It holds a status register and a configuration register. It decodes single-bit mode 0 instructions from the chip-select, clock and data-in lines and drives the data-out line with an enable. The block works in a system clock domain: it synchronises the SPI lines and finds their edges. SPI clock phases must therefore last several system clocks.

Register writes and bulk erase are committed on the rising edge of chip select. They run a behavioural busy timer that stands in for the flash array. Two error-injection inputs model failed erase and program operations. The write-protect pin combines with a status bit to form a hardware-locked mode.

Top module: `fp_protect_unit`

## Requirements
- R1: After reset the status byte and the configuration byte both read 0x00, and `spi_miso_oe` is 0.
- R2: Opcode 0x06 (a complete one-byte transaction, not busy) sets the write-enable bit. Opcodes 0x01 and 0xC7 have no effect while that bit is 0.
- R3: Opcode 0x01 with 2 or 3 complete bytes writes the lock bit (status bit 7) and the protect field (status bits 4:2) from the first data byte. With 3 bytes it also writes the configuration byte from the second data byte. The operation then holds status bit 0 (busy) high for WRR_CYCLES clocks and clears write-enable when busy ends.
- R4: When the lock bit is 1 and `wp_n` is low, opcode 0x01 is rejected and every register stays unchanged. With `wp_n` high the same write is accepted.
- R5: Opcode 0xC7 starts an erase only when the protect field is 000. Otherwise it is dropped without busy, without an error flag and without changing write-enable.
- R6: An erase that ends while `inj_erase_fail` is 1 sets the erase-error flag (status bit 5). A pulse on `inj_prog_fail` sets the program-error flag (status bit 6). Both flags stay set across other commands.
- R7: Opcode 0x30 clears both error flags, and it is accepted even while busy.
- R8: While busy, opcodes 0x06, 0x01 and 0xC7 are ignored. Status read (0x05) and configuration read (0x35) still work during busy.
- R9: For opcodes 0x05 and 0x35, `spi_miso_oe` stays 0 through the 8 opcode clocks. After that the register is sent MSB first and repeats every 8 clocks while chip select stays low.
- R10: A transaction that ends with a partial byte (chip select rising mid-byte) has no effect.
- R11: The status byte is laid out as {lock, program-error, erase-error, protect[2:0], write-enable, busy}. The configuration byte holds bit 1 (quad), bit 2 (parameter placement), bit 3 (volatile-protect select) and bit 5 (top/bottom protect); all its other bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| spi_sck | input | 1 | SPI serial clock, mode 0 |
| spi_cs_n | input | 1 | SPI chip select, active low |
| spi_mosi | input | 1 | Serial data in, sampled on rising SCK |
| wp_n | input | 1 | Write-protect pin, active low |
| inj_erase_fail | input | 1 | Erase outcome when the erase timer ends (1 = failed) |
| inj_prog_fail | input | 1 | One-clock pulse marking a failed program |
| spi_miso | output | 1 | Serial data out, changes on falling SCK |
| spi_miso_oe | output | 1 | Output enable for spi_miso |

## Verification
A wrong register bit appears in the next status or configuration read, within the first data byte after the opcode. A bad busy counter shows as a wrong busy or write-enable bit on the first read after the expected end of the operation. A broken lock or protect gate shows as a protect field or configuration byte that changed when it should not have. A faulty serialiser shows as a bit error, or an early enable, in the very read that exposes it.

// File: rtl/fp_pkg.sv
// Shared constants for the flash protection register unit.
// Assumes single-bit SPI transfers of 8-bit bytes.
package fp_pkg;
    localparam int BYTE_W = 8;
    localparam int BIT_W  = $clog2(BYTE_W);

    localparam logic [7:0] OP_WRITE_REGS = 8'h01;
    localparam logic [7:0] OP_READ_STAT  = 8'h05;
    localparam logic [7:0] OP_READ_CFG   = 8'h35;
    localparam logic [7:0] OP_CLEAR_ERR  = 8'h30;
    localparam logic [7:0] OP_WRITE_EN   = 8'h06;
    localparam logic [7:0] OP_ERASE_ALL  = 8'hC7;

    // configuration bits that software may write
    localparam logic [7:0] CFG_WMASK = 8'h2E;

    typedef enum logic [1:0] {
        JOB_NONE  = 2'd0,
        JOB_WRITE = 2'd1,
        JOB_ERASE = 2'd2
    } job_e;
endpackage

// File: rtl/fp_spi_front.sv
// SPI mode 0 front end: synchronises the SPI lines into clk, counts bits and
// bytes, captures the opcode and two data bytes, and serialises read data.
// Assumes every SCK phase lasts longer than SYNC_STAGES+1 system clocks.
module fp_spi_front
    import fp_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int CNT_W       = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             spi_sck,
    input  logic             spi_cs_n,
    input  logic             spi_mosi,
    input  logic             wp_n,
    input  logic [7:0]       tx_byte,
    output logic             wp_s,
    output logic [7:0]       opcode,
    output logic [7:0]       dat0,
    output logic [7:0]       dat1,
    output logic [CNT_W-1:0] byte_cnt,
    output logic             end_evt,
    output logic             whole,
    output logic             spi_miso,
    output logic             spi_miso_oe
);
    localparam logic [3:0] SYNC_RST = 4'b1010; // wp, mosi, cs, sck

    logic [3:0]       sync_q [SYNC_STAGES];
    logic             sck_s, cs_s, si_s, sck_d, cs_d;
    logic             sck_rise, sck_fall, read_mode;
    logic [BIT_W-1:0] bit_cnt;
    logic [7:0]       rx_q, rx_next, tx_sh;

    // Synchroniser chain for the four asynchronous pins.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < SYNC_STAGES; i++) sync_q[i] <= SYNC_RST;
        end else begin
            sync_q[0] <= {wp_n, spi_mosi, spi_cs_n, spi_sck};
            for (int i = 1; i < SYNC_STAGES; i++) sync_q[i] <= sync_q[i-1];
        end
    end

    assign sck_s = sync_q[SYNC_STAGES-1][0];
    assign cs_s  = sync_q[SYNC_STAGES-1][1];
    assign si_s  = sync_q[SYNC_STAGES-1][2];
    assign wp_s  = sync_q[SYNC_STAGES-1][3];

    // Previous-cycle copies used for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sck_d <= 1'b0;
            cs_d  <= 1'b1;
        end else begin
            sck_d <= sck_s;
            cs_d  <= cs_s;
        end
    end

    assign sck_rise  = sck_s && !sck_d;
    assign sck_fall  = !sck_s && sck_d;
    assign end_evt   = cs_s && !cs_d;
    assign whole     = (bit_cnt == '0);
    assign rx_next   = {rx_q[6:0], si_s};
    assign read_mode = (byte_cnt != '0) &&
                       (opcode == OP_READ_STAT || opcode == OP_READ_CFG);

    // Receive shifter, bit/byte counters and byte capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bit_cnt  <= '0;
            byte_cnt <= '0;
            rx_q     <= '0;
            opcode   <= '0;
            dat0     <= '0;
            dat1     <= '0;
        end else if (cs_s) begin
            bit_cnt  <= '0;
            byte_cnt <= '0;
        end else if (sck_rise) begin
            rx_q    <= rx_next;
            bit_cnt <= bit_cnt + 1'b1;
            if (bit_cnt == BIT_W'(BYTE_W - 1)) begin
                if (byte_cnt != '1) byte_cnt <= byte_cnt + 1'b1;
                case (byte_cnt)
                    CNT_W'(0): opcode <= rx_next;
                    CNT_W'(1): dat0   <= rx_next;
                    CNT_W'(2): dat1   <= rx_next;
                    default:   ;
                endcase
            end
        end
    end

    // Transmit shifter: load at the byte boundary, shift on each falling SCK.
    always_ff @(posedge clk) begin
        if (!rst_n || cs_s) begin
            tx_sh       <= '0;
            spi_miso_oe <= 1'b0;
        end else if (sck_fall && read_mode) begin
            spi_miso_oe <= 1'b1;
            if (bit_cnt == '0) tx_sh <= tx_byte;
            else               tx_sh <= {tx_sh[6:0], 1'b0};
        end
    end

    assign spi_miso = tx_sh[7];

    // R9: no output drive while the opcode byte is still arriving
    p_quiet_opcode_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_cnt == '0) |-> !spi_miso_oe);

    // R10: leaving a transaction always restarts bit counting at zero
    p_abort_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
        end_evt |=> (bit_cnt == '0 && byte_cnt == '0));
endmodule

// File: rtl/fp_reg_ctrl.sv
// Status/configuration registers, command acceptance, write protection and
// the behavioural busy timer. Commands are committed on the chip-select rise
// reported by the front end, using its still-valid byte snapshot.
module fp_reg_ctrl
    import fp_pkg::*;
#(
    parameter int WRR_CYCLES   = 64,
    parameter int ERASE_CYCLES = 256,
    parameter int CNT_W        = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wp_s,
    input  logic [7:0]       opcode,
    input  logic [7:0]       dat0,
    input  logic [7:0]       dat1,
    input  logic [CNT_W-1:0] byte_cnt,
    input  logic             end_evt,
    input  logic             whole,
    input  logic             inj_erase_fail,
    input  logic             inj_prog_fail,
    output logic [7:0]       tx_byte
);
    localparam int MAX_CYC = (WRR_CYCLES > ERASE_CYCLES) ? WRR_CYCLES : ERASE_CYCLES;
    localparam int TMR_W   = $clog2(MAX_CYC + 1);

    logic             lock_q, wel_q, eerr_q, perr_q;
    logic [2:0]       prot_q;
    logic [7:0]       cfg_q;
    logic [TMR_W-1:0] timer_q;
    job_e             job_q;
    logic             busy, hw_lock, one_byte, done;
    logic             acc_wren, acc_clr, acc_erase, acc_write;
    logic [7:0]       status;
    logic             unused_dat;

    assign unused_dat = ^{dat0[6:5], dat0[1:0], dat1 & ~CFG_WMASK};

    assign busy     = (timer_q != '0);
    assign done     = (timer_q == TMR_W'(1));
    assign hw_lock  = lock_q && !wp_s;
    assign one_byte = end_evt && whole && (byte_cnt == CNT_W'(1));

    assign acc_wren  = one_byte && opcode == OP_WRITE_EN && !busy;
    assign acc_clr   = one_byte && opcode == OP_CLEAR_ERR;
    assign acc_erase = one_byte && opcode == OP_ERASE_ALL && !busy &&
                       wel_q && prot_q == 3'b000;
    assign acc_write = end_evt && whole && opcode == OP_WRITE_REGS &&
                       (byte_cnt == CNT_W'(2) || byte_cnt == CNT_W'(3)) &&
                       !busy && wel_q && !hw_lock;

    // Busy timer and the job it belongs to.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            timer_q <= '0;
            job_q   <= JOB_NONE;
        end else if (acc_write) begin
            timer_q <= TMR_W'(WRR_CYCLES);
            job_q   <= JOB_WRITE;
        end else if (acc_erase) begin
            timer_q <= TMR_W'(ERASE_CYCLES);
            job_q   <= JOB_ERASE;
        end else if (busy) begin
            timer_q <= timer_q - 1'b1;
            if (done) job_q <= JOB_NONE;
        end
    end

    // Write-enable latch: set by its opcode, cleared when an operation ends.
    always_ff @(posedge clk) begin
        if (!rst_n)        wel_q <= 1'b0;
        else if (acc_wren) wel_q <= 1'b1;
        else if (done)     wel_q <= 1'b0;
    end

    // Non-volatile protection fields, written only by an accepted write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lock_q <= 1'b0;
            prot_q <= 3'b000;
            cfg_q  <= 8'h00;
        end else if (acc_write) begin
            lock_q <= dat0[7];
            prot_q <= dat0[4:2];
            if (byte_cnt == CNT_W'(3)) cfg_q <= dat1 & CFG_WMASK;
        end
    end

    // Sticky error flags: clear command first, a new failure wins.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            eerr_q <= 1'b0;
            perr_q <= 1'b0;
        end else begin
            if (acc_clr) begin
                eerr_q <= 1'b0;
                perr_q <= 1'b0;
            end
            if (done && job_q == JOB_ERASE && inj_erase_fail) eerr_q <= 1'b1;
            if (inj_prog_fail) perr_q <= 1'b1;
        end
    end

    assign status  = {lock_q, perr_q, eerr_q, prot_q, wel_q, busy};
    assign tx_byte = (opcode == OP_READ_CFG) ? cfg_q : status;

    // R3: write-enable is gone the cycle after an operation finishes
    p_wel_drop_r3: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !wel_q);

    // R4: while locked by pin and bit, protection fields cannot move
    p_locked_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        hw_lock |=> ($stable(prot_q) && $stable(cfg_q) && $stable(lock_q)));

    // R5: erase with a nonzero protect field never starts the timer
    p_erase_blocked_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (one_byte && opcode == OP_ERASE_ALL && !busy && prot_q != 3'b000) |=> !busy);

    // R6: error flags only fall through the clear command
    p_err_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ((eerr_q || perr_q) && !acc_clr) |=> (eerr_q >= $past(eerr_q) && perr_q >= $past(perr_q)));

    // R8: write-enable is frozen while an operation is still running
    p_busy_wel_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> $stable(wel_q));
endmodule

// File: rtl/fp_protect_unit.sv
// Top level of the flash protection register unit: joins the SPI front end
// and the register/command controller. All logic runs on clk.
module fp_protect_unit #(
    parameter int SYNC_STAGES  = 2,
    parameter int WRR_CYCLES   = 64,
    parameter int ERASE_CYCLES = 256,
    parameter int CNT_W        = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic spi_sck,
    input  logic spi_cs_n,
    input  logic spi_mosi,
    input  logic wp_n,
    input  logic inj_erase_fail,
    input  logic inj_prog_fail,
    output logic spi_miso,
    output logic spi_miso_oe
);
    logic             wp_s, end_evt, whole;
    logic [7:0]       opcode, dat0, dat1, tx_byte;
    logic [CNT_W-1:0] byte_cnt;

    fp_spi_front #(.SYNC_STAGES(SYNC_STAGES), .CNT_W(CNT_W)) u_front (
        .clk(clk), .rst_n(rst_n), .spi_sck(spi_sck), .spi_cs_n(spi_cs_n),
        .spi_mosi(spi_mosi), .wp_n(wp_n), .tx_byte(tx_byte), .wp_s(wp_s),
        .opcode(opcode), .dat0(dat0), .dat1(dat1), .byte_cnt(byte_cnt),
        .end_evt(end_evt), .whole(whole), .spi_miso(spi_miso),
        .spi_miso_oe(spi_miso_oe)
    );

    fp_reg_ctrl #(.WRR_CYCLES(WRR_CYCLES), .ERASE_CYCLES(ERASE_CYCLES),
                  .CNT_W(CNT_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .wp_s(wp_s), .opcode(opcode), .dat0(dat0),
        .dat1(dat1), .byte_cnt(byte_cnt), .end_evt(end_evt), .whole(whole),
        .inj_erase_fail(inj_erase_fail), .inj_prog_fail(inj_prog_fail),
        .tx_byte(tx_byte)
    );
endmodule

// File: tb/fp_protect_unit_bench.sv
module fp_protect_unit_bench;
    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 6;
    localparam int WRR_C      = 1200;
    localparam int ERASE_C    = 1400;

    logic clk = 1'b0, rst_n = 1'b0;
    logic sck = 1'b0, cs_n = 1'b1, mosi = 1'b0, wp_n = 1'b1;
    logic inj_e = 1'b0, inj_p = 1'b0;
    logic miso, miso_oe;
    int   checks = 0, errors = 0;
    bit   finished = 1'b0;

    // behavioural reference state
    bit       m_lock, m_wel, m_eerr, m_perr, m_busy, m_erase_job;
    bit [2:0] m_prot;
    bit [7:0] m_cfg;

    always #(CLK_PERIOD/2) clk = ~clk;

    fp_protect_unit #(.WRR_CYCLES(WRR_C), .ERASE_CYCLES(ERASE_C)) u_fp_protect_unit (
        .clk(clk), .rst_n(rst_n), .spi_sck(sck), .spi_cs_n(cs_n),
        .spi_mosi(mosi), .wp_n(wp_n), .inj_erase_fail(inj_e),
        .inj_prog_fail(inj_p), .spi_miso(miso), .spi_miso_oe(miso_oe)
    );

    function automatic logic [7:0] m_stat();
        return {m_lock, m_perr, m_eerr, m_prot, m_wel, m_busy};
    endfunction

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic clks(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send_bits(input logic [7:0] b, input int n);
        for (int i = 7; i > 7 - n; i--) begin
            mosi = b[i];
            clks(HALF);
            sck = 1'b1;
            clks(HALF);
            sck = 1'b0;
        end
    endtask

    task automatic cs_low();
        cs_n = 1'b0;
        clks(HALF);
    endtask

    task automatic cs_high();
        clks(HALF);
        cs_n = 1'b1;
        clks(4 * HALF);
    endtask

    // Complete command of n bytes; the model applies the acceptance rules.
    task automatic cmd(input logic [7:0] op, input int n, input logic [7:0] d0, input logic [7:0] d1);
        cs_low();
        send_bits(op, 8);
        if (n > 1) send_bits(d0, 8);
        if (n > 2) send_bits(d1, 8);
        cs_high();
        case (op)
            8'h06: if (n == 1 && !m_busy) m_wel = 1;
            8'h30: if (n == 1) begin m_eerr = 0; m_perr = 0; end
            8'h01: if ((n == 2 || n == 3) && !m_busy && m_wel && !(m_lock && !wp_n)) begin
                m_lock = d0[7];
                m_prot = d0[4:2];
                if (n == 3) m_cfg = d1 & 8'h2E;
                m_busy = 1; m_erase_job = 0;
            end
            8'hC7: if (n == 1 && !m_busy && m_wel && m_prot == 0) begin
                m_busy = 1; m_erase_job = 1;
            end
            default: ;
        endcase
    endtask

    // Read a register for nrep bytes and compare each bit sample.
    task automatic read_chk(input logic [7:0] op, input logic [7:0] exp, input int nrep, input string req);
        logic [7:0] got;
        logic       oe_seen;
        oe_seen = 1'b0;
        cs_low();
        for (int i = 7; i >= 0; i--) begin
            mosi = op[i];
            clks(HALF);
            oe_seen = oe_seen | miso_oe;
            sck = 1'b1;
            clks(HALF);
            sck = 1'b0;
        end
        chk({req, " R9 oe during opcode"}, {7'd0, oe_seen}, 8'h00);
        for (int r = 0; r < nrep; r++) begin
            oe_seen = 1'b1;
            for (int i = 7; i >= 0; i--) begin
                clks(HALF);
                got[i]  = miso;
                oe_seen = oe_seen & miso_oe;
                sck = 1'b1;
                clks(HALF);
                sck = 1'b0;
            end
            chk({req, " R9 oe during data"}, {7'd0, oe_seen}, 8'h01);
            chk(req, got, exp);
        end
        cs_high();
    endtask

    task automatic wait_idle();
        clks(ERASE_C + 100);
        if (m_busy) begin
            m_busy = 0;
            m_wel  = 0;
            if (m_erase_job && inj_e) m_eerr = 1;
        end
    endtask

    initial begin
        clks(5);
        rst_n = 1'b1;
        clks(5);
        chk("R1 oe after reset", {7'd0, miso_oe}, 8'h00);
        read_chk(8'h05, m_stat(), 1, "R1 R11 status reset");
        read_chk(8'h35, 8'h00, 1, "R1 config reset");

        cmd(8'h01, 2, 8'h1C, 8'h00);
        read_chk(8'h05, m_stat(), 1, "R2 write without enable ignored");
        cmd(8'h06, 1, 8'h00, 8'h00);
        read_chk(8'h05, 8'h02, 1, "R2 enable sets bit 1");

        cmd(8'h01, 3, 8'h0C, 8'hFF);
        read_chk(8'h05, m_stat(), 1, "R3 busy after write");
        read_chk(8'h35, 8'h2E, 1, "R8 R11 config readable while busy");
        cmd(8'h01, 2, 8'h10, 8'h00);
        wait_idle();
        read_chk(8'h05, 8'h0C, 1, "R3 R8 write done, busy write dropped");

        cmd(8'h06, 1, 8'h00, 8'h00);
        cmd(8'hC7, 1, 8'h00, 8'h00);
        read_chk(8'h05, 8'h0E, 1, "R5 erase refused with protect set");

        cmd(8'h01, 2, 8'h80, 8'h00);
        wait_idle();
        read_chk(8'h05, 8'h80, 1, "R3 two-byte write");
        read_chk(8'h35, 8'h2E, 1, "R3 config kept by two-byte write");

        wp_n = 1'b0;
        clks(10);
        cmd(8'h06, 1, 8'h00, 8'h00);
        cmd(8'h01, 3, 8'h00, 8'h00);
        read_chk(8'h05, 8'h82, 1, "R4 locked write rejected");
        read_chk(8'h35, 8'h2E, 1, "R4 config locked");
        wp_n = 1'b1;
        clks(10);
        cmd(8'h01, 3, 8'h00, 8'h00);
        wait_idle();
        read_chk(8'h05, m_stat(), 1, "R4 unlocked write accepted");
        read_chk(8'h35, 8'h00, 1, "R4 config cleared");

        cs_low();
        send_bits(8'h06, 5);
        cs_high();
        read_chk(8'h05, 8'h00, 1, "R10 partial byte ignored");

        inj_e = 1'b1;
        cmd(8'h06, 1, 8'h00, 8'h00);
        cmd(8'hC7, 1, 8'h00, 8'h00);
        read_chk(8'h05, 8'h03, 1, "R5 erase started");
        wait_idle();
        read_chk(8'h05, 8'h20, 1, "R6 erase failure flag");
        inj_e = 1'b0;
        inj_p = 1'b1;
        clks(1);
        inj_p = 1'b0;
        m_perr = 1;
        cmd(8'h06, 1, 8'h00, 8'h00);
        read_chk(8'h05, m_stat(), 3, "R6 R9 sticky flags, repeated read");

        cmd(8'h01, 2, 8'h00, 8'h00);
        cmd(8'h30, 1, 8'h00, 8'h00);
        read_chk(8'h05, 8'h03, 1, "R7 clear accepted while busy");
        wait_idle();
        read_chk(8'h05, 8'h00, 1, "R7 idle after clear");

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule